// File: doc/BRIEF.md
# SPI Flash Command Engine with Shared Ring Buffer

This block issues one command at a time to a serial flash device over a four-wire SPI link. A host on a simple byte-wide register bus loads an opcode, a packed count of bytes to send and bytes to receive, and the payload bytes. It then sets a start bit. The engine frames the command with chip select. It shifts out the opcode first and then the payload bytes taken from an eight-byte ring buffer. Last it clocks in the requested number of response bytes.

The ring buffer has one visible three-bit pointer, and the host port and the shifter both use it. Every byte that leaves the ring is replaced by the byte captured during its own shift. Response bytes go into the slots that follow. To send, the host clears the pointer, writes the payload and clears the pointer again before starting. To collect the response, it clears the pointer and reads the ring back. The payload slots then hold what the device returned while the payload went out.

Top module: `spi_ring_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the pointer reads 0, the busy flags read 0, the opcode and count registers read 0x00, and all eight ring slots read 0x00.
- R2: The opcode register is at offset 0x0 and reads back what was written. Its value is always the first byte shifted out, MSB first, and it never occupies a ring slot.
- R3: The count register is at offset 0x1. Bits 7:4 give the receive count and bits 3:0 give the payload count, not counting the opcode. A command shifts exactly 1 + payload + receive bytes while chip select is low.
- R4: An access to the data port at offset 0xC reads or writes the slot at the pointer. The pointer then advances by one, wrapping from 7 to 0.
- R5: Bits 2:0 of offset 0xD return the pointer. When idle, writing a 1 to bit 4 of offset 0x2 sets the pointer to 0.
- R6: When idle, writing a 1 to bit 0 of offset 0x2 starts a command. While the command runs, bit 0 of offset 0x2 and bit 7 of offset 0x3 (bit 31 of the 32-bit control word at 0x0) read 1. Both return to 0 on their own when it ends.
- R7: Payload bytes are sent from consecutive slots starting at the pointer. Each slot used is overwritten with the byte received during its shift, and a payload longer than the ring sends already-overwritten slots. During receive bytes MOSI carries 0xFF and the captured bytes fill the next slots. The pointer ends at (start + payload + receive) mod 8.
- R8: With a payload count of 0, every requested receive byte is captured and stored, and none is dropped.
- R9: The serial clock idles low. Each high phase lasts HALF_DIV system clocks. MISO is sampled on the rising edge, and MOSI changes only while the serial clock is low.
- R10: Chip select stays low without a break from the first opcode bit to the last received bit, falls once per command, and is high for at least 2*HALF_DIV system clocks before the next command.
- R11: While busy, writes to the opcode, count, control and data-port registers have no effect, and data-port reads do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected offset (combinational) |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The assertions assume that the host presents at most one register access per cycle and that MISO is stable around each rising serial clock. The stimulus meets this by driving the bus only between clock edges. A device model in the bench changes MISO only on falling serial clock edges. The pointer-end property also takes the count register as constant during a command; the bench tries to break this deliberately with writes while busy, and the design must ignore them. Payload counts above eight and a zero payload are in the stimulus so that ring wrap and the receive-only case are both reached.

// File: rtl/spi_ring_pkg.sv
package spi_ring_pkg;

    localparam int BUS_AW = 4;

    // register offsets
    localparam logic [BUS_AW-1:0] OFF_OPCODE = 4'h0;
    localparam logic [BUS_AW-1:0] OFF_COUNT  = 4'h1;
    localparam logic [BUS_AW-1:0] OFF_CTRL   = 4'h2;
    localparam logic [BUS_AW-1:0] OFF_STAT   = 4'h3;
    localparam logic [BUS_AW-1:0] OFF_DATA   = 4'hC;
    localparam logic [BUS_AW-1:0] OFF_PTR    = 4'hD;

    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_CLR_BIT = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OP,
        ST_LOAD_TX,
        ST_TX,
        ST_LOAD_RX,
        ST_RX,
        ST_GAP
    } eng_state_e;

endpackage

// File: rtl/spi_ring_fifo.sv
module spi_ring_fifo #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr,
    output logic [7:0]       rd_data
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W-1:0]      ptr;
    } ring_t;

    ring_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            d.mem[q.ptr] = wr_data;
        end
        if (clr) begin
            d.ptr = '0;
        end else if (adv) begin
            d.ptr = (q.ptr == PTR_W'(DEPTH - 1)) ? '0 : q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ptr     = q.ptr;
    assign rd_data = q.mem[q.ptr];

    // a write with no clear lands where the pointer stood and is readable there
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (q.mem[$past(q.ptr)] == $past(wr_data)));

endmodule

// File: rtl/spi_ring_shifter.sv
module spi_ring_shifter #(
    parameter int HALF_DIV = 2,
    localparam int DIV_W = $clog2(HALF_DIV) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       active
);
    typedef struct packed {
        logic             active;
        logic             sck;
        logic [2:0]       bits;
        logic [DIV_W-1:0] div;
        logic [7:0]       tx_sr;
        logic [7:0]       rx_sr;
        logic             done;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (load) begin
            d.active = 1'b1;
            d.sck    = 1'b0;
            d.bits   = '0;
            d.div    = '0;
            d.tx_sr  = tx_byte;
        end else if (q.active) begin
            if (q.div == DIV_W'(HALF_DIV - 1)) begin
                d.div = '0;
                if (!q.sck) begin
                    d.sck   = 1'b1;
                    d.rx_sr = {q.rx_sr[6:0], miso};
                end else begin
                    d.sck = 1'b0;
                    if (q.bits == 3'd7) begin
                        d.active = 1'b0;
                        d.done   = 1'b1;
                    end else begin
                        d.bits  = q.bits + 1'b1;
                        d.tx_sr = {q.tx_sr[6:0], 1'b0};
                    end
                end
            end else begin
                d.div = q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck     = q.sck;
    assign mosi    = q.tx_sr[7];
    assign done    = q.done;
    assign rx_byte = q.rx_sr;
    assign active  = q.active;

    // mode 0: data never moves on the rising edge
    p_mosi_hold_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(mosi));

    // clock idles low between bytes
    p_sck_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sck);

    // a finished byte leaves the clock low
    p_done_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sck && $fell(sck)));

endmodule

// File: rtl/spi_ring_ctrl.sv
module spi_ring_ctrl
    import spi_ring_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int PTR_W   = $clog2(DEPTH);   // DEPTH must be a power of two
    localparam int CNT_W   = 4;               // two counts share one byte
    localparam int GAP_CYC = 2 * HALF_DIV;
    localparam int GAP_W   = $clog2(GAP_CYC) + 1;
    localparam int HI_W    = $clog2(GAP_CYC + 1) + 1;

    typedef struct packed {
        eng_state_e       st;
        logic [7:0]       opcode;
        logic [CNT_W-1:0] rx_cnt;
        logic [CNT_W-1:0] tx_cnt;
        logic [CNT_W-1:0] left;
        logic [GAP_W-1:0] gap;
        logic             cs_n;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, opcode: '0, rx_cnt: '0, tx_cnt: '0,
                                 left: '0, gap: '0, cs_n: 1'b1};

    ctl_t q, d;

    logic             sh_load, sh_done, sh_active;
    logic [7:0]       sh_tx, sh_rx;
    logic             eng_wr, dp_wr, dp_rd, host_clr;
    logic [PTR_W-1:0] ring_ptr;
    logic [7:0]       ring_rd;
    logic             host_wr, host_rd, busy;

    assign host_wr = bus_sel && bus_wr;
    assign host_rd = bus_sel && !bus_wr;
    assign busy    = (q.st != ST_IDLE);

    always_comb begin
        d        = q;
        sh_load  = 1'b0;
        sh_tx    = 8'hFF;
        eng_wr   = 1'b0;
        dp_wr    = 1'b0;
        dp_rd    = 1'b0;
        host_clr = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (host_wr) begin
                    case (bus_addr)
                        OFF_OPCODE: d.opcode = bus_wdata;
                        OFF_COUNT: begin
                            d.rx_cnt = bus_wdata[7:4];
                            d.tx_cnt = bus_wdata[3:0];
                        end
                        OFF_CTRL: begin
                            host_clr = bus_wdata[CTRL_CLR_BIT];
                            if (bus_wdata[CTRL_GO_BIT]) begin
                                d.st    = ST_OP;
                                d.cs_n  = 1'b0;
                                sh_load = 1'b1;
                                sh_tx   = q.opcode;
                            end
                        end
                        OFF_DATA: dp_wr = 1'b1;
                        default: ;
                    endcase
                end
                if (host_rd && bus_addr == OFF_DATA) begin
                    dp_rd = 1'b1;
                end
            end
            ST_OP: begin
                if (sh_done) begin
                    if (q.tx_cnt != '0) begin
                        d.left = q.tx_cnt;
                        d.st   = ST_LOAD_TX;
                    end else if (q.rx_cnt != '0) begin
                        d.left = q.rx_cnt;
                        d.st   = ST_LOAD_RX;
                    end else begin
                        d.st   = ST_GAP;
                        d.cs_n = 1'b1;
                        d.gap  = '0;
                    end
                end
            end
            ST_LOAD_TX: begin
                sh_load = 1'b1;
                sh_tx   = ring_rd;
                d.st    = ST_TX;
            end
            ST_TX: begin
                if (sh_done) begin
                    eng_wr = 1'b1;
                    d.left = q.left - 1'b1;
                    if (q.left != CNT_W'(1)) begin
                        d.st = ST_LOAD_TX;
                    end else if (q.rx_cnt != '0) begin
                        d.left = q.rx_cnt;
                        d.st   = ST_LOAD_RX;
                    end else begin
                        d.st   = ST_GAP;
                        d.cs_n = 1'b1;
                        d.gap  = '0;
                    end
                end
            end
            ST_LOAD_RX: begin
                sh_load = 1'b1;
                sh_tx   = 8'hFF;
                d.st    = ST_RX;
            end
            ST_RX: begin
                if (sh_done) begin
                    eng_wr = 1'b1;
                    d.left = q.left - 1'b1;
                    if (q.left == CNT_W'(1)) begin
                        d.st   = ST_GAP;
                        d.cs_n = 1'b1;
                        d.gap  = '0;
                    end else begin
                        d.st = ST_LOAD_RX;
                    end
                end
            end
            ST_GAP: begin
                d.gap = q.gap + 1'b1;
                if (q.gap == GAP_W'(GAP_CYC - 1)) begin
                    d.st = ST_IDLE;
                end
            end
            default: d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    spi_ring_fifo #(.DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (host_clr),
        .wr_en   (dp_wr || eng_wr),
        .wr_data (eng_wr ? sh_rx : bus_wdata),
        .adv     (dp_wr || dp_rd || eng_wr),
        .ptr     (ring_ptr),
        .rd_data (ring_rd)
    );

    spi_ring_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_byte (sh_rx),
        .active  (sh_active)
    );

    assign spi_cs_n = q.cs_n;

    always_comb begin
        case (bus_addr)
            OFF_OPCODE: bus_rdata = q.opcode;
            OFF_COUNT:  bus_rdata = {q.rx_cnt, q.tx_cnt};
            OFF_CTRL:   bus_rdata = {7'b0, busy};
            OFF_STAT:   bus_rdata = {busy, 7'b0};
            OFF_DATA:   bus_rdata = ring_rd;
            OFF_PTR:    bus_rdata = 8'(ring_ptr);
            default:    bus_rdata = 8'h00;
        endcase
    end

    // checker state: high-time of chip select and pointer at command start
    logic [HI_W-1:0]  hi_cnt_q;
    logic [PTR_W-1:0] snap_ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q   <= '1;
            snap_ptr_q <= '0;
        end else begin
            if (!spi_cs_n)            hi_cnt_q <= '0;
            else if (hi_cnt_q != '1)  hi_cnt_q <= hi_cnt_q + 1'b1;
            if (q.st == ST_OP)        snap_ptr_q <= ring_ptr;
        end
    end

    p_start_sets_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_wr && bus_addr == OFF_CTRL && bus_wdata[CTRL_GO_BIT]) |=> busy);

    p_sck_inside_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n);

    p_cs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_cnt_q >= HI_W'(GAP_CYC)));

    p_shift_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sh_active |-> busy);

    p_ptr_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (ring_ptr == PTR_W'(snap_ptr_q + q.tx_cnt + q.rx_cnt)));

    p_opcode_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr && bus_addr == OFF_OPCODE) |=> $stable(q.opcode));

    p_ptr_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_GAP && bus_sel) |=> $stable(ring_ptr));

endmodule

// File: tb/spi_ring_ctrl_tb.sv
`timescale 1ns/1ps
module spi_ring_ctrl_tb;
    localparam int HALF = 2;
    localparam int NV   = 7;
    // {opcode, rx count, tx count}
    localparam logic [15:0] VECS [NV] = '{
        16'h9F30, 16'h0343, 16'h0205, 16'h0B44, 16'h0500, 16'h5A6A, 16'hABF2
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       spi_cs_n, spi_sck, spi_mosi, spi_miso;

    int errors = 0, checks = 0;

    always #2.5 clk = ~clk;

    spi_ring_ctrl #(.DEPTH(8), .HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic [7:0] resp(int k);
        return 8'((k * 29 + 92) & 255);
    endfunction

    // device model: shifts resp(k) out on falling edges, records MOSI on rising
    int sb_byte = 0, sb_bit = 0, cap_n = 0, cap_bits = 0, cs_falls = 0;
    logic [7:0] cap_sr = '0;
    logic [7:0] cap [64];
    logic [7:0] rsp_now;
    assign rsp_now  = resp(sb_byte);
    assign spi_miso = rsp_now[7 - sb_bit];

    always @(negedge spi_cs_n) begin
        sb_byte = 0; sb_bit = 0; cap_n = 0; cap_bits = 0; cs_falls++;
    end
    always @(negedge spi_sck) begin
        if (sb_bit == 7) begin sb_bit = 0; sb_byte++; end
        else sb_bit++;
    end
    always @(posedge spi_sck) begin
        cap_sr = {cap_sr[6:0], spi_mosi};
        cap_bits++;
        if (cap_bits == 8) begin
            if (cap_n < 64) cap[cap_n] = cap_sr;
            cap_n++; cap_bits = 0;
        end
    end

    // mode-0 monitor, sampled away from the active edge
    int hrun = 0, bad_half = 0, mosi_viol = 0, cs_viol = 0;
    logic prev_sck = 1'b0, prev_mosi = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_sck && spi_sck && spi_mosi !== prev_mosi) mosi_viol++;
            if (spi_sck && spi_cs_n) cs_viol++;
            if (spi_sck) hrun++;
            else if (hrun != 0) begin
                if (hrun != HALF) bad_half++;
                hrun = 0;
            end
        end
        prev_sck = spi_sck; prev_mosi = spi_mosi;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        int guard = 0;
        do begin
            bus_read(4'h2, v);
            guard++;
        end while (v[0] && guard < 5000);
        check(!v[0], "R6 busy self-clears", v, 0);
    endtask

    logic [7:0] model [8];

    task automatic run_cmd(input int vi, input logic [7:0] op, input int tx, input int rx,
                           input bit poke);
        logic [7:0] v;
        logic [7:0] sent [64];
        int p;
        string tag;
        tag = poke ? "R11" : "R2/R3";
        bus_write(4'h2, 8'h10);
        bus_read(4'hD, v);
        check(v[2:0] == 3'd0, "R5 pointer clear", v, 0);
        bus_write(4'h1, {4'(rx), 4'(tx)});
        bus_write(4'h0, op);
        bus_read(4'h0, v);
        check(v == op, "R2 opcode readback", v, op);
        bus_read(4'h1, v);
        check(v == {4'(rx), 4'(tx)}, "R3 count readback", v, {4'(rx), 4'(tx)});
        p = 0;
        for (int j = 0; j < tx; j++) begin
            bus_write(4'hC, 8'((vi * 17 + j * 3 + 1) & 255));
            model[p] = 8'((vi * 17 + j * 3 + 1) & 255);
            p = (p + 1) % 8;
        end
        bus_read(4'hD, v);
        check(v[2:0] == 3'(tx % 8), "R4 pointer after port writes", v, tx % 8);
        bus_write(4'h2, 8'h10);
        cs_falls = 0;
        bus_write(4'h2, 8'h01);
        if (poke) begin
            bus_write(4'h0, 8'h00);
            bus_write(4'h1, 8'hFF);
            bus_write(4'hC, 8'hEE);
            bus_read(4'hC, v);
            bus_write(4'h2, 8'h10);
            bus_write(4'h2, 8'h01);
        end
        bus_read(4'h2, v);
        check(v[0], "R6 start bit reads busy", v, 1);
        bus_read(4'h3, v);
        check(v[7], "R6 status bit 7 reads busy", v, 8'h80);
        wait_idle();
        // expected traffic and ring contents
        sent[0] = op;
        p = 0;
        for (int i = 0; i < tx; i++) begin
            sent[1 + i] = model[p];
            model[p] = resp(1 + i);
            p = (p + 1) % 8;
        end
        for (int i = 0; i < rx; i++) begin
            sent[1 + tx + i] = 8'hFF;
            model[p] = resp(1 + tx + i);
            p = (p + 1) % 8;
        end
        check(cap_n == 1 + tx + rx, "R3 bytes framed", cap_n, 1 + tx + rx);
        check(cs_falls == 1, "R10 one chip-select frame", cs_falls, 1);
        check(cap[0] == op, "R2 opcode sent first", cap[0], op);
        for (int i = 1; i < 1 + tx + rx && i < cap_n; i++)
            check(cap[i] == sent[i], "R7 MOSI byte", cap[i], sent[i]);
        bus_read(4'h0, v);
        check(v == op, {tag, " opcode kept"}, v, op);
        bus_read(4'h1, v);
        check(v == {4'(rx), 4'(tx)}, {tag, " count kept"}, v, {4'(rx), 4'(tx)});
        bus_read(4'hD, v);
        check(v[2:0] == 3'(p), "R7 pointer end", v, p);
        bus_write(4'h2, 8'h10);
        for (int s = 0; s < 8; s++) begin
            bus_read(4'hC, v);
            check(v == model[s], (tx == 0) ? "R8 ring slot" : "R7 ring slot", v, model[s]);
        end
        bus_read(4'hD, v);
        check(v[2:0] == 3'd0, "R4 pointer wraps to 0", v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int s = 0; s < 8; s++) model[s] = 8'h00;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(spi_cs_n == 1'b1, "R1 cs high", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R1 sck low", spi_sck, 0);
        bus_read(4'h0, v); check(v == 8'h00, "R1 opcode zero", v, 0);
        bus_read(4'h1, v); check(v == 8'h00, "R1 count zero", v, 0);
        bus_read(4'h2, v); check(v == 8'h00, "R1 not busy", v, 0);
        bus_read(4'h3, v); check(v == 8'h00, "R1 status zero", v, 0);
        bus_read(4'hD, v); check(v == 8'h00, "R1 pointer zero", v, 0);
        for (int s = 0; s < 8; s++) begin
            bus_read(4'hC, v);
            check(v == 8'h00, "R1 ring zero", v, 0);
        end
        // vector table
        for (int vi = 0; vi < NV; vi++)
            run_cmd(vi, VECS[vi][15:8], int'(VECS[vi][3:0]), int'(VECS[vi][7:4]), 1'b0);
        // directed: accesses while busy are ignored (R11)
        run_cmd(9, 8'h3B, 1, 2, 1'b1);
        // directed: receive-only after a full ring (R8)
        run_cmd(10, 8'h4C, 0, 9, 1'b0);
        // R9 mode-0 timing and R10 framing summary
        check(bad_half == 0, "R9 sck high phase length", bad_half, 0);
        check(mosi_viol == 0, "R9 MOSI stable while sck high", mosi_viol, 0);
        check(cs_viol == 0, "R10 sck only inside frame", cs_viol, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule